// File: doc/BRIEF.md
# Punctured Convolutional Encoder

This block turns a serial stream of data bits into a serial stream of coded bits. Each accepted data bit enters a feed-forward shift register of constraint length 7. Two parity taps form a rate-1/2 code pair, called X and Y here. A puncturer then drops some of those coded bits in a fixed repeating pattern, which raises the effective code rate to 2/3, 3/4 or 7/8. The bits that are kept leave one per clock on `code_bit`, and `code_vld` marks each one.

Data comes in on a valid/ready handshake. When both bits of a pair are kept, the second bit needs an extra clock, and `data_rdy` drops for that clock so that no data bit is lost. There is no stall on the output side. The pattern position starts again from its first entry after reset, and also whenever `rate_sel` changes.

Top module: `punc_conv_enc`

## Requirements
- R1: While reset is low and in the first cycle after it, `code_vld` is 0 and `data_rdy` is 1. The shift register is all zeros and the pattern position is at its first entry.
- R2: For each accepted bit, X is the XOR of the taps of octal 171 and Y is the XOR of the taps of octal 133. The generator MSB taps the newest bit. After a single 1 is followed by zeros at rate 1/2, the output is 11 10 11 11 00 01 11.
- R3: With `rate_sel`=0 (rate 1/2), every accepted bit sends X and then Y.
- R4: With `rate_sel`=1 (rate 2/3), the period is 2 input bits. X is kept at position 0 only and Y at both positions.
- R5: With `rate_sel`=2 (rate 3/4), the period is 3. X is kept at positions 0 and 2, and Y at positions 0 and 1.
- R6: With `rate_sel`=3 (rate 7/8), the period is 7. X is kept at positions 0, 4 and 6, and Y at positions 0, 1, 2, 3 and 5.
- R7: When a pair keeps both bits, `data_rdy` is 0 in the clock that sends Y. A data bit offered in that clock is not taken.
- R8: The first kept bit of an accepted data bit appears, with `code_vld`=1, in the clock after acceptance. When a position keeps both bits, X comes before Y. No other clock has `code_vld`=1.
- R9: A change of `rate_sel` puts the pattern position back to 0 for the next accepted bit.
- R10: While `data_vld` is 0, no coded bit is sent and the shift register does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_sel | input | 2 | Code rate: 0=1/2, 1=2/3, 2=3/4, 3=7/8 |
| data_bit | input | 1 | Data bit to encode |
| data_vld | input | 1 | `data_bit` is offered |
| data_rdy | output | 1 | The block takes the offered bit at this edge |
| code_bit | output | 1 | Coded bit |
| code_vld | output | 1 | `code_bit` holds a kept bit |

## Verification
The bench builds the block with its default parameters: constraint length 7 and generators 171 and 133. With these values the impulse response can be checked against fixed literal bit strings. The 3-bit pattern position covers the 7-entry period of the 7/8 pattern, so the bench reaches wrap-around at every rate. A mid-stream rate change, stalls during two-bit pairs, and idle gaps then exercise the restart, back-pressure and hold behaviour against a reference model in the bench.

// File: rtl/pce_pkg.sv
package pce_pkg;

  typedef enum logic [1:0] {
    RATE_1_2 = 2'd0,
    RATE_2_3 = 2'd1,
    RATE_3_4 = 2'd2,
    RATE_7_8 = 2'd3
  } rate_e;

  localparam int PH_W = 3;

  // number of data bits in one puncture period
  function automatic logic [PH_W-1:0] pce_period(input logic [1:0] r);
    case (r)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      2'd2:    return 3'd3;
      default: return 3'd7;
    endcase
  endfunction

  // {keep_x, keep_y} for a given rate and position; bit n of a mask is position n
  function automatic logic [1:0] pce_keep(input logic [1:0] r, input logic [PH_W-1:0] ph);
    logic [6:0] mx, my;
    case (r)
      2'd0:    begin mx = 7'b0000001; my = 7'b0000001; end
      2'd1:    begin mx = 7'b0000001; my = 7'b0000011; end
      2'd2:    begin mx = 7'b0000101; my = 7'b0000011; end
      default: begin mx = 7'b1010001; my = 7'b0101111; end
    endcase
    return {mx[ph], my[ph]};
  endfunction

  // XOR of the taps selected by a generator
  function automatic logic pce_parity(input logic [31:0] win, input logic [31:0] gen);
    return ^(win & gen);
  endfunction

endpackage

// File: rtl/pce_shift_enc.sv
module pce_shift_enc #(
  parameter int K = 7,
  parameter logic [K-1:0] G_X = 7'o171,
  parameter logic [K-1:0] G_Y = 7'o133
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  input  logic din,
  output logic x_bit,
  output logic y_bit
);
  import pce_pkg::*;

  localparam int M = K - 1;

  logic [M-1:0] sr;   // sr[M-1] newest past bit, sr[0] oldest
  logic [K-1:0] win;

  assign win   = {din, sr};
  assign x_bit = pce_parity(32'(win), 32'(G_X));
  assign y_bit = pce_parity(32'(win), 32'(G_Y));

  always_ff @(posedge clk) begin
    if (!rst_n)        sr <= '0;
    else if (shift_en) sr <= win[K-1:1];
  end

  AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(sr)); // R10
  AST_NEWEST_IN: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (sr[M-1] == $past(din))); // R2

endmodule

// File: rtl/pce_punct_seq.sv
module pce_punct_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rate_sel,
  input  logic       adv,
  output logic [1:0] keep,
  output logic       rate_chg
);
  import pce_pkg::*;

  logic [1:0]      rate_q;
  logic [PH_W-1:0] phase, eff_ph, nxt_ph, last_ph;

  assign rate_chg = (rate_sel != rate_q);
  assign eff_ph   = rate_chg ? '0 : phase;
  assign last_ph  = pce_period(rate_sel) - 3'd1;
  assign keep     = pce_keep(rate_sel, eff_ph);

  always_comb begin
    nxt_ph = eff_ph;
    if (adv) nxt_ph = (eff_ph == last_ph) ? '0 : eff_ph + 3'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_q <= RATE_1_2;
      phase  <= '0;
    end else begin
      rate_q <= rate_sel;
      phase  <= nxt_ph;
    end
  end

  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    phase < pce_period(rate_q)); // R6
  AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_chg && !adv) |=> (phase == '0)); // R9
  AST_KEEP_SOME: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (keep != 2'b00)); // R8

endmodule

// File: rtl/pce_serializer.sv
module pce_serializer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       x_bit,
  input  logic       y_bit,
  input  logic [1:0] keep,
  output logic       sbit,
  output logic       svld,
  output logic       pend
);
  logic pend_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sbit     <= 1'b0;
      svld     <= 1'b0;
      pend     <= 1'b0;
      pend_bit <= 1'b0;
    end else if (load) begin
      svld     <= |keep;
      sbit     <= keep[1] ? x_bit : y_bit;
      pend     <= &keep;
      pend_bit <= y_bit;
    end else if (pend) begin
      svld <= 1'b1;
      sbit <= pend_bit;
      pend <= 1'b0;
    end else begin
      svld <= 1'b0;
    end
  end

  AST_NO_LOAD_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !load); // R7
  AST_PEND_SENDS: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> svld); // R8

endmodule

// File: rtl/punc_conv_enc.sv
module punc_conv_enc #(
  parameter int K = 7,
  parameter logic [K-1:0] G_X = 7'o171,
  parameter logic [K-1:0] G_Y = 7'o133
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rate_sel,
  input  logic       data_bit,
  input  logic       data_vld,
  output logic       data_rdy,
  output logic       code_bit,
  output logic       code_vld
);
  logic       acc;
  logic       x_bit, y_bit;
  logic [1:0] keep;
  logic       rate_chg;
  logic       pend;

  assign data_rdy = !pend;
  assign acc      = data_vld && data_rdy;

  pce_shift_enc #(.K(K), .G_X(G_X), .G_Y(G_Y)) u_enc (
    .clk(clk), .rst_n(rst_n), .shift_en(acc), .din(data_bit),
    .x_bit(x_bit), .y_bit(y_bit)
  );

  pce_punct_seq u_seq (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .adv(acc),
    .keep(keep), .rate_chg(rate_chg)
  );

  pce_serializer u_ser (
    .clk(clk), .rst_n(rst_n), .load(acc), .x_bit(x_bit), .y_bit(y_bit),
    .keep(keep), .sbit(code_bit), .svld(code_vld), .pend(pend)
  );

  AST_PEND_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    !data_rdy |=> data_rdy); // R7
  AST_OUT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    code_vld |-> ($past(acc) || !$past(data_rdy))); // R8
  AST_HALF_TWO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && rate_sel == 2'd0) |=> (code_vld && !data_rdy)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_vld && data_rdy) |=> !code_vld); // R10
  AST_RESTART_USED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && rate_chg) |=> code_vld); // R9

endmodule

// File: tb/sim_punc_conv_enc.sv
`timescale 1ns/1ps
module sim_punc_conv_enc;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] rate_sel = 2'd0;
  logic       data_bit = 1'b0;
  logic       data_vld = 1'b0;
  logic       data_rdy, code_bit, code_vld;

  int n_run = 0;
  int n_fail = 0;

  punc_conv_enc u0 (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .data_bit(data_bit),
    .data_vld(data_vld), .data_rdy(data_rdy), .code_bit(code_bit), .code_vld(code_vld)
  );

  always #5 clk = ~clk;

  // reference model state
  bit    hist [0:6];
  int    ref_ph;
  int    ref_rate;
  bit    exp_q[$];
  bit    cap_q[$];
  string cur_tag = "R3";

  localparam string TAP_X = "1111001";
  localparam string TAP_Y = "1011011";

  function automatic string pat_x(int r);
    case (r) 0: return "1"; 1: return "10"; 2: return "101"; default: return "1000101"; endcase
  endfunction
  function automatic string pat_y(int r);
    case (r) 0: return "1"; 1: return "11"; 2: return "110"; default: return "1111010"; endcase
  endfunction
  function automatic string rate_tag(int r);
    case (r) 0: return "R3"; 1: return "R4"; 2: return "R5"; default: return "R6"; endcase
  endfunction

  task automatic ref_reset();
    for (int i = 0; i < 7; i++) hist[i] = 0;
    ref_ph = 0;
    ref_rate = 0;
    exp_q.delete();
    cap_q.delete();
  endtask

  task automatic ref_push(bit b, int r);
    bit    xv, yv;
    string px, py;
    if (r != ref_rate) begin ref_ph = 0; ref_rate = r; end
    for (int i = 6; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = b;
    xv = 0; yv = 0;
    for (int t = 0; t < 7; t++) begin
      if (TAP_X[t] == "1") xv ^= hist[t];
      if (TAP_Y[t] == "1") yv ^= hist[t];
    end
    px = pat_x(r); py = pat_y(r);
    if (px[ref_ph] == "1") exp_q.push_back(xv);
    if (py[ref_ph] == "1") exp_q.push_back(yv);
    ref_ph = (ref_ph + 1) % px.len();
  endtask

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // output monitor
  always @(negedge clk) begin
    if (rst_n && code_vld) begin
      cap_q.push_back(code_bit);
      if (exp_q.size() == 0) check(0, "R8", "unexpected coded bit", 1, 0);
      else begin
        bit e;
        e = exp_q.pop_front();
        check(code_bit == e, cur_tag, "coded bit", code_bit, e);
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0; data_vld = 1'b0;
    repeat (3) @(negedge clk);
    check(code_vld == 0, "R1", "code_vld in reset", code_vld, 0);
    check(data_rdy == 1, "R1", "data_rdy in reset", data_rdy, 1);
    ref_reset();
    rst_n = 1'b1;
    @(negedge clk);
    check(code_vld == 0 && data_rdy == 1, "R1", "idle after reset", {code_vld, data_rdy}, 1);
  endtask

  task automatic send_bit(bit b);
    data_vld = 1'b1; data_bit = b;
    ref_push(b, int'(rate_sel));
    @(negedge clk);
    data_vld = 1'b0;
    while (!data_rdy) @(negedge clk);
  endtask

  task automatic idle(int n);
    data_vld = 1'b0;
    repeat (n) begin data_bit = ~data_bit; @(negedge clk); end
  endtask

  task automatic drain_check(string tag);
    idle(4);
    check(exp_q.size() == 0, tag, "pending expected bits", exp_q.size(), 0);
  endtask

  // stimulus table: {rate, 16 data bits}
  localparam logic [17:0] VEC [8] = '{
    {2'd0, 16'hA5C3}, {2'd1, 16'h1F0E}, {2'd2, 16'hB3D2}, {2'd3, 16'h7A61},
    {2'd3, 16'hFFFF}, {2'd2, 16'h0001}, {2'd1, 16'hC8E5}, {2'd0, 16'h5A3C}
  };

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog expired (R1-related run hang)");
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    ref_reset();
    do_reset();

    // table walk, each rate R3..R6
    for (int v = 0; v < 8; v++) begin
      rate_sel = VEC[v][17:16];
      cur_tag  = rate_tag(int'(VEC[v][17:16]));
      do_reset();
      for (int i = 15; i >= 0; i--) begin
        send_bit(VEC[v][i]);
        if ((v % 2 == 1) && (i % 4 == 2)) idle(1);
      end
      drain_check(cur_tag);
    end

    // R2: impulse response at rate 1/2
    rate_sel = 2'd0; cur_tag = "R2";
    do_reset();
    send_bit(1'b1);
    for (int i = 0; i < 6; i++) send_bit(1'b0);
    drain_check("R2");
    begin
      string want;
      want = "11101111000111";
      check(cap_q.size() == 14, "R2", "impulse length", cap_q.size(), 14);
      for (int i = 0; i < 14 && i < cap_q.size(); i++)
        check(cap_q[i] == (want[i] == "1"), "R2", "impulse bit", cap_q[i], want[i] == "1");
    end

    // R7: offer a bit during the second-bit clock; it must not be taken
    rate_sel = 2'd0; cur_tag = "R7";
    do_reset();
    data_vld = 1'b1; data_bit = 1'b1; ref_push(1'b1, 0);
    @(negedge clk);
    check(data_rdy == 0, "R7", "data_rdy while Y pending", data_rdy, 0);
    data_bit = 1'b1;   // still offered, must be ignored
    @(negedge clk);
    data_vld = 1'b0;
    check(data_rdy == 1, "R7", "data_rdy after Y", data_rdy, 1);
    send_bit(1'b0); send_bit(1'b0);
    drain_check("R7");

    // R10: idle with toggling data leaves state untouched
    rate_sel = 2'd3; cur_tag = "R10";
    do_reset();
    send_bit(1'b1); send_bit(1'b0);
    idle(10);
    check(exp_q.size() == 0, "R10", "bits during idle", exp_q.size(), 0);
    for (int i = 0; i < 9; i++) send_bit(i[0]);
    drain_check("R10");

    // R9: rate change mid-period restarts the pattern
    rate_sel = 2'd3; cur_tag = "R9";
    do_reset();
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    rate_sel = 2'd2;
    idle(2);
    for (int i = 0; i < 5; i++) send_bit(i[1]);
    rate_sel = 2'd1;
    for (int i = 0; i < 5; i++) send_bit(~i[0]);
    drain_check("R9");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule